// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Hub

This block is the register front end for a bank of DMA channels. A simple 32-bit register bus reaches a window for each channel and a handful of global registers. The channel windows hold the settings a channel engine needs: a descriptor address split into high and low words, a transfer length and a block length. Receive channels also have a run bit. The block drives these settings out to the channel engines. The engines themselves, and the data they move, sit outside this block.

Channels come in pairs. The even channel of a pair receives and the odd channel transmits. Each pair owns a 0x40-byte slice of the address map, and the transmit registers start 0x18 bytes into that slice. Each channel raises a one-cycle completion pulse. The pulse lands in a sticky status register that software clears by writing ones. An enable register masks the status. A read-only pending view shows status AND enable, and the single interrupt output is high while any pending bit is set. A separate global register selects 32-bit addressing for the channel engines.

Top module: `dma_reg_hub`

## Requirements
- R1: After reset every channel register, the run bits, the address-mode bit, the status register and the enable register are zero, and `irq` is low.
- R2: Channel c belongs to pair c/2. Its window base is (c/2)*0x40 for an even c and (c/2)*0x40+0x18 for an odd c. Relative to that base, the descriptor high word is at +0x00, the descriptor low word at +0x04, the length at +0x0C and the block length at +0x10. Each of these registers is 32 bits wide, reads back what was written, and drives the slice [c*32 +: 32] of its output bus.
- R3: A receive window has a run bit at bit 0 of base+0x14, and it drives `rx_run[c/2]`. A transmit window has nothing at +0x14: that offset reads zero and a write to it changes nothing.
- R4: A pulse on `ch_done[i]` sets status bit i, read at 0x080000. The bit stays set until software clears it.
- R5: Writing to 0x080000 clears each status bit whose write-data bit is 1 and leaves the other bits as they were. Writing 0xFFFFFFFF clears every bit.
- R6: If a completion pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R7: The register at 0x080004 reads status AND enable. Writes to it have no effect.
- R8: `irq` is high exactly when status AND enable is nonzero. Writing 0 to the enable register drives `irq` low.
- R9: The enable register at 0x080008 holds one bit per channel. Bits above the channel count read as zero.
- R10: The address-mode register at 0x34 stores write-data bit 0, drives `addr32_mode` and reads back that bit with every other bit zero.
- R11: Any address not named in R2, R3, R4, R7, R9 or R10 reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe of the register bus |
| reg_addr | input | ADDR_W | Byte address for the read or write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, available in the same cycle |
| ch_done | input | NUM_PAIRS*2 | Completion pulse for each channel |
| ch_desc_hi | output | NUM_PAIRS*2*DATA_W | Descriptor high word of each channel |
| ch_desc_lo | output | NUM_PAIRS*2*DATA_W | Descriptor low word of each channel |
| ch_len | output | NUM_PAIRS*2*DATA_W | Length register of each channel |
| ch_blk | output | NUM_PAIRS*2*DATA_W | Block length register of each channel |
| rx_run | output | NUM_PAIRS | Run bit of the receive channel in each pair |
| addr32_mode | output | 1 | Selects 32-bit addressing |
| irq | output | 1 | Interrupt, high while any enabled status bit is set |

## Verification
The channel windows are tested with values that differ for every channel and every register. This exposes a wrong pair stride, a wrong transmit offset, or two registers swapped within a window. Writes go to the holes next to the registers: the +0x08 gap, the +0x14 offset of a transmit window, 0x30, and the spare word after the global registers. These writes must leave every register as it was, which separates a decode that matches exact addresses from one that ignores some address bits. The status tests use completion patterns that leave several bits set, clear only part of them, and apply the enable mask afterwards. One case puts a completion pulse and a clearing write on the same bit in the same cycle, to check that the completion wins. Writing to the pending view must change nothing.

// File: rtl/dma_hub_pkg.sv
package dma_hub_pkg;

   // address map (byte addresses)
   localparam int unsigned PAIR_SPAN  = 32'h40;
   localparam int unsigned TX_SHIFT   = 32'h18;
   localparam int unsigned WIN_BYTES  = 32'h18;
   localparam int unsigned MODE_ADDR  = 32'h34;
   localparam int unsigned STAT_ADDR  = 32'h80000;
   localparam int unsigned PEND_ADDR  = 32'h80004;
   localparam int unsigned ENAB_ADDR  = 32'h80008;

   // offsets inside one channel window
   localparam logic [4:0] OFF_HI  = 5'h00;
   localparam logic [4:0] OFF_LO  = 5'h04;
   localparam logic [4:0] OFF_LEN = 5'h0C;
   localparam logic [4:0] OFF_BLK = 5'h10;
   localparam logic [4:0] OFF_RUN = 5'h14;

   typedef enum logic [2:0] {
      CR_NONE,
      CR_HI,
      CR_LO,
      CR_LEN,
      CR_BLK,
      CR_RUN
   } chreg_e;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_hub_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit IS_RX  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [4:0]        off,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] desc_hi,
   output logic [DATA_W-1:0] desc_lo,
   output logic [DATA_W-1:0] len,
   output logic [DATA_W-1:0] blk,
   output logic              run
);

   chreg_e which;

   always_comb begin
      which = CR_NONE;
      if (sel) begin
         unique case (off)
            OFF_HI:  which = CR_HI;
            OFF_LO:  which = CR_LO;
            OFF_LEN: which = CR_LEN;
            OFF_BLK: which = CR_BLK;
            OFF_RUN: which = IS_RX ? CR_RUN : CR_NONE;
            default: which = CR_NONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         desc_hi <= '0;
         desc_lo <= '0;
         len     <= '0;
         blk     <= '0;
      end else if (wr) begin
         if (which == CR_HI)  desc_hi <= wdata;
         if (which == CR_LO)  desc_lo <= wdata;
         if (which == CR_LEN) len     <= wdata;
         if (which == CR_BLK) blk     <= wdata;
      end
   end

   generate
      if (IS_RX) begin : g_run
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     run <= 1'b0;
            else if (wr && which == CR_RUN) run <= wdata[0];
         end
      end else begin : g_norun
         assign run = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (which)
         CR_HI:   rdata = desc_hi;
         CR_LO:   rdata = desc_lo;
         CR_LEN:  rdata = len;
         CR_BLK:  rdata = blk;
         CR_RUN:  rdata = DATA_W'(run);
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] done,
   input  logic              clr_wr,
   input  logic              en_wr,
   input  logic [NUM_CH-1:0] wbits,
   output logic [NUM_CH-1:0] status,
   output logic [NUM_CH-1:0] enable,
   output logic [NUM_CH-1:0] pending,
   output logic              irq
);

   logic [NUM_CH-1:0] clr_mask;

   assign clr_mask = clr_wr ? wbits : '0;

   // a completion in the same cycle as a clear keeps its bit set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr_mask) | done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     enable <= '0;
      else if (en_wr) enable <= wbits;
   end

   assign pending = status & enable;
   assign irq     = |pending;

endmodule

// File: rtl/dma_reg_hub.sv
module dma_reg_hub
   import dma_hub_pkg::*;
#(
   parameter int NUM_PAIRS = 2,
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_wr,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic [DATA_W-1:0]             reg_wdata,
   output logic [DATA_W-1:0]             reg_rdata,
   input  logic [NUM_PAIRS*2-1:0]        ch_done,
   output logic [NUM_PAIRS*2*DATA_W-1:0] ch_desc_hi,
   output logic [NUM_PAIRS*2*DATA_W-1:0] ch_desc_lo,
   output logic [NUM_PAIRS*2*DATA_W-1:0] ch_len,
   output logic [NUM_PAIRS*2*DATA_W-1:0] ch_blk,
   output logic [NUM_PAIRS-1:0]          rx_run,
   output logic                          addr32_mode,
   output logic                          irq
);

   localparam int NUM_CH = NUM_PAIRS * 2;

   generate
      if (ADDR_W < 20 || ADDR_W > 32) begin : g_bad_addr
         $error("dma_reg_hub: ADDR_W must be within 20..32");
      end
      if (DATA_W < NUM_CH || DATA_W < 32) begin : g_bad_data
         $error("dma_reg_hub: DATA_W must be >= 32 and >= channel count");
      end
      if (NUM_PAIRS < 1 || NUM_PAIRS * PAIR_SPAN > MODE_ADDR + STAT_ADDR - PAIR_SPAN) begin : g_bad_pairs
         $error("dma_reg_hub: NUM_PAIRS out of range");
      end
   endgenerate

   logic [31:0]       addr_x;
   logic [DATA_W-1:0] chan_rd [NUM_CH];
   logic              run_w   [NUM_CH];
   logic [NUM_CH-1:0] status_q, enable_q, pending_w;
   logic              hit_mode, hit_stat, hit_pend, hit_enab;

   assign addr_x   = 32'(reg_addr);
   assign hit_mode = (addr_x == MODE_ADDR);
   assign hit_stat = (addr_x == STAT_ADDR);
   assign hit_pend = (addr_x == PEND_ADDR);
   assign hit_enab = (addr_x == ENAB_ADDR);

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         localparam int unsigned BASE = (c / 2) * PAIR_SPAN + ((c % 2) != 0 ? TX_SHIFT : 0);
         logic       sel;
         logic [4:0] off;

         assign sel = (addr_x >= BASE) && (addr_x < BASE + WIN_BYTES);
         assign off = 5'(addr_x - BASE);

         dma_chan_regs #(
            .DATA_W (DATA_W),
            .IS_RX  ((c % 2) == 0)
         ) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (sel),
            .wr      (reg_wr),
            .off     (off),
            .wdata   (reg_wdata),
            .rdata   (chan_rd[c]),
            .desc_hi (ch_desc_hi[c*DATA_W +: DATA_W]),
            .desc_lo (ch_desc_lo[c*DATA_W +: DATA_W]),
            .len     (ch_len[c*DATA_W +: DATA_W]),
            .blk     (ch_blk[c*DATA_W +: DATA_W]),
            .run     (run_w[c])
         );
      end

      for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
         // the transmit side drives a constant zero
         assign rx_run[p] = run_w[2*p] | run_w[2*p+1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   addr32_mode <= 1'b0;
      else if (reg_wr && hit_mode)  addr32_mode <= reg_wdata[0];
   end

   dma_irq_agg #(
      .NUM_CH (NUM_CH)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .done    (ch_done),
      .clr_wr  (reg_wr && hit_stat),
      .en_wr   (reg_wr && hit_enab),
      .wbits   (reg_wdata[NUM_CH-1:0]),
      .status  (status_q),
      .enable  (enable_q),
      .pending (pending_w),
      .irq     (irq)
   );

   always_comb begin
      reg_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) reg_rdata = reg_rdata | chan_rd[c];
      if (hit_mode) reg_rdata = DATA_W'(addr32_mode);
      if (hit_stat) reg_rdata = DATA_W'(status_q);
      if (hit_pend) reg_rdata = DATA_W'(pending_w);
      if (hit_enab) reg_rdata = DATA_W'(enable_q);
   end

endmodule

// File: rtl/dma_reg_hub_chk.sv
module dma_reg_hub_chk
   import dma_hub_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 20,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [NUM_CH-1:0] ch_done,
   input logic [NUM_CH-1:0] status_q,
   input logic [NUM_CH-1:0] enable_q,
   input logic              addr32_mode,
   input logic              irq
);

   logic wr_stat, wr_enab, wr_mode;
   assign wr_stat = reg_wr && (32'(reg_addr) == STAT_ADDR);
   assign wr_enab = reg_wr && (32'(reg_addr) == ENAB_ADDR);
   assign wr_mode = reg_wr && (32'(reg_addr) == MODE_ADDR);

   // R4
   done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_done != '0) |=> ((status_q & $past(ch_done)) == $past(ch_done)));

   // R4
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

   // R5
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat |=> ((status_q & $past(reg_wdata[NUM_CH-1:0]) & ~$past(ch_done)) == '0));

   // R6
   done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && ((ch_done & reg_wdata[NUM_CH-1:0]) != '0))
      |=> ((status_q & $past(ch_done & reg_wdata[NUM_CH-1:0])) == $past(ch_done & reg_wdata[NUM_CH-1:0])));

   // R8
   irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == ((status_q & enable_q) != '0));

   // R9
   enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_enab |=> $stable(enable_q));

   // R10
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mode |=> $stable(addr32_mode));

endmodule

bind dma_reg_hub dma_reg_hub_chk #(
   .NUM_CH (NUM_PAIRS * 2),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .ch_done     (ch_done),
   .status_q    (status_q),
   .enable_q    (enable_q),
   .addr32_mode (addr32_mode),
   .irq         (irq)
);

// File: tb/dma_reg_hub_tb.sv
`timescale 1ns/1ps
module dma_reg_hub_tb;

   localparam int NP = 2;
   localparam int NC = NP * 2;
   localparam int AW = 20;
   localparam int DW = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr = 1'b0;
   logic [AW-1:0]   reg_addr = '0;
   logic [DW-1:0]   reg_wdata = '0;
   logic [DW-1:0]   reg_rdata;
   logic [NC-1:0]   ch_done = '0;
   logic [NC*DW-1:0] ch_desc_hi, ch_desc_lo, ch_len, ch_blk;
   logic [NP-1:0]   rx_run;
   logic            addr32_mode, irq;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dma_reg_hub #(.NUM_PAIRS(NP), .ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_done(ch_done),
      .ch_desc_hi(ch_desc_hi), .ch_desc_lo(ch_desc_lo), .ch_len(ch_len),
      .ch_blk(ch_blk), .rx_run(rx_run), .addr32_mode(addr32_mode), .irq(irq)
   );

   task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input logic [NC-1:0] v);
      @(negedge clk);
      ch_done = v;
      @(negedge clk);
      ch_done = '0;
   endtask

   function automatic logic [AW-1:0] cbase(input int c);
      return AW'((c / 2) * 'h40 + ((c % 2) != 0 ? 'h18 : 0));
   endfunction

   function automatic logic [DW-1:0] pat(input int c, input int k);
      return 32'hC000_0000 | DW'(c << 8) | DW'(k);
   endfunction

   task automatic t_reset();
      logic [DW-1:0] d;
      rd(20'h80000, d); chk("R1", "status", d, 0);
      rd(20'h80008, d); chk("R1", "enable", d, 0);
      rd(20'h00034, d); chk("R1", "mode reg", d, 0);
      chk("R1", "irq", DW'(irq), 0);
      chk("R1", "rx_run", DW'(rx_run), 0);
      chk("R1", "addr32_mode", DW'(addr32_mode), 0);
      chk("R1", "desc_lo ch3", ch_desc_lo[3*DW +: DW], 0);
   endtask

   task automatic t_chan_regs();
      logic [DW-1:0] d;
      for (int c = 0; c < NC; c++) begin
         wr(cbase(c) + 20'h00, pat(c, 1));
         wr(cbase(c) + 20'h04, pat(c, 2));
         wr(cbase(c) + 20'h0C, pat(c, 3));
         wr(cbase(c) + 20'h10, pat(c, 4));
      end
      for (int c = 0; c < NC; c++) begin
         chk("R2", "desc_hi out", ch_desc_hi[c*DW +: DW], pat(c, 1));
         chk("R2", "desc_lo out", ch_desc_lo[c*DW +: DW], pat(c, 2));
         chk("R2", "len out",     ch_len[c*DW +: DW],     pat(c, 3));
         chk("R2", "blk out",     ch_blk[c*DW +: DW],     pat(c, 4));
         rd(cbase(c) + 20'h04, d); chk("R2", "desc_lo read", d, pat(c, 2));
         rd(cbase(c) + 20'h10, d); chk("R2", "blk read", d, pat(c, 4));
      end
   endtask

   task automatic t_run();
      logic [DW-1:0] d;
      wr(20'h54, 32'hFFFF);
      chk("R3", "rx_run after pair1 write", DW'(rx_run), 2);
      rd(20'h54, d); chk("R3", "run read", d, 1);
      wr(20'h2C, 32'h5);
      rd(20'h2C, d); chk("R3", "tx +0x14 read", d, 0);
      chk("R3", "rx_run after tx +0x14 write", DW'(rx_run), 2);
      wr(20'h54, 32'h0);
      chk("R3", "rx_run cleared", DW'(rx_run), 0);
   endtask

   task automatic t_mode();
      logic [DW-1:0] d;
      wr(20'h34, 32'hFFFF_FFFF);
      rd(20'h34, d); chk("R10", "mode read", d, 1);
      chk("R10", "addr32_mode set", DW'(addr32_mode), 1);
      wr(20'h34, 32'h2);
      chk("R10", "addr32_mode cleared by bit0=0", DW'(addr32_mode), 0);
   endtask

   task automatic t_unmapped();
      logic [DW-1:0] d;
      wr(20'h08, 32'hABCD);
      rd(20'h08, d); chk("R11", "hole +0x08", d, 0);
      wr(20'h30, 32'h1234);
      rd(20'h30, d); chk("R11", "0x30", d, 0);
      wr(20'h8000C, 32'hFFFF_FFFF);
      rd(20'h8000C, d); chk("R11", "0x8000C", d, 0);
      rd(20'h80008, d); chk("R11", "enable untouched", d, 0);
      chk("R11", "ch0 registers untouched", ch_desc_lo[0 +: DW] ^ ch_len[0 +: DW], pat(0, 2) ^ pat(0, 3));
      chk("R11", "ch1 registers untouched", ch_desc_hi[DW +: DW], pat(1, 1));
      chk("R11", "mode untouched", DW'(addr32_mode), 0);
   endtask

   task automatic t_status();
      logic [DW-1:0] d;
      pulse(4'b0101);
      rd(20'h80000, d); chk("R4", "status after pulse", d, 5);
      chk("R8", "irq masked", DW'(irq), 0);
      rd(20'h80004, d); chk("R7", "pending masked", d, 0);
      wr(20'h80008, 32'hFFFF_FFFF);
      rd(20'h80008, d); chk("R9", "enable width", d, 32'hF);
      rd(20'h80004, d); chk("R7", "pending", d, 5);
      chk("R8", "irq raised", DW'(irq), 1);
      wr(20'h80000, 32'h1);
      rd(20'h80000, d); chk("R5", "partial clear", d, 4);
      chk("R8", "irq still high", DW'(irq), 1);
      wr(20'h80004, 32'h0);
      rd(20'h80004, d); chk("R7", "pending write ignored", d, 4);
      // R6: completion on bit1 with a clear of bits 1 and 2 in one cycle
      @(negedge clk);
      ch_done = 4'b0010; reg_addr = 20'h80000; reg_wdata = 32'h6; reg_wr = 1'b1;
      @(negedge clk);
      ch_done = '0; reg_wr = 1'b0;
      rd(20'h80000, d); chk("R6", "done wins over clear", d, 2);
      wr(20'h80008, 32'h0);
      chk("R8", "irq low when enable zero", DW'(irq), 0);
      rd(20'h80000, d); chk("R4", "status kept under mask", d, 2);
      pulse(4'b1000);
      wr(20'h80000, 32'hFFFF_FFFF);
      rd(20'h80000, d); chk("R5", "clear all", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_chan_regs();
      t_run();
      t_mode();
      t_unmapped();
      t_status();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule